// File: doc/BRIEF.md
# Two-Pin Register-Mapped General-Purpose I/O Port

This block controls two general-purpose pads through three byte-wide registers on a simple synchronous bus. A write strobe is sampled on a rising clock edge together with an address and data byte. A read strobe is sampled the same way, and the addressed register appears on the read-data port one cycle later. The read data then holds until the next read.

One control register carries, for each pin, an output data bit and a direction bit. A set direction bit makes the pin bidirectional: its output buffer is enabled and drives the stored data bit. A cleared direction bit turns the output buffer off. The input path is always live, so the status register reports the real pad level even when the block itself drives the pin. Raw pad levels pass through a two-flop synchronizer and are not filtered.

A mode register can take either pin out of digital use so that the pad can carry an analog reference. Pin 0 can then output the internal reference and pin 1 can accept an external one. While a pin is taken over this way, its output enable is forced off, its analog-select strobe to the pad mux is raised, and its status bit reads 0.

Top module: `gpio2_port`

## Requirements
- R1: After synchronous reset the pads come up bidirectional with low outputs: pad_oe = 2'b11, pad_out = 2'b00 and ana_sel = 2'b00. The control register (0x40) reads 0x30, the mode register (0x70) reads 0x00, and bus_rdata is 0x00.
- R2: A write to address 0x40 takes effect on the clock edge where bus_wr is sampled. Bit 0 is pin 0 output data, bit 1 is pin 1 output data, bit 4 is pin 0 direction and bit 5 is pin 1 direction. Bits 2, 3, 6 and 7 ignore writes and read as 0.
- R3: For a pin that is not bypassed, direction 1 gives pad_oe = 1 with pad_out equal to the stored data bit. Direction 0 gives pad_oe = 0 and pad_out = 0.
- R4: Address 0x41 reports the pad level of pin i in bit i, after a two-flop synchronizer. A read sampled on the first or second edge after a pad change returns the old level, and a read on the third edge returns the new one. Bits 7:2 read 0.
- R5: The input path stays active when a pin drives, so reading 0x41 returns the level present on the pad, including the level the block drives itself.
- R6: Writes to the read-only address 0x41 change no register and no pad output.
- R7: In the mode register (0x70), bit 0 bypasses pin 0 and bit 1 bypasses pin 1. Bits 7:2 ignore writes and read as 0.
- R8: While a pin is bypassed, ana_sel for that pin is 1 and pad_oe and pad_out are 0 whatever its direction bit is. Its bit in 0x41 reads 0. Clearing the bypass restores the digital behaviour from the stored control bits.
- R9: Reads of any unmapped address return 0x00, and writes to unmapped addresses change nothing.
- R10: bus_rdata changes only on an edge where bus_rd is sampled high, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, sampled on the rising edge |
| bus_rdata | output | 8 | Registered read data, held between reads |
| pad_in | input | 2 | Raw pad input levels |
| pad_oe | output | 2 | Per-pin output buffer enable |
| pad_out | output | 2 | Per-pin driven value |
| ana_sel | output | 2 | Per-pin analog routing select for the pad mux |

## Verification
The bench models each pad as whatever the block drives when its buffer is enabled, and an external level otherwise. This lets it check that readback in output mode returns the driven level, and that a design which gated the input path by direction would report the external level instead. It times the synchronizer edge by edge: a read one edge too early or too late shows up as a wrong status byte. It sets the bypass while the direction bits are 1 and checks that the output enable drops and that the status bit is masked. A design that let direction win over bypass would still drive the pad. It also writes all-ones to reserved bits, to the read-only address and to unmapped addresses. A decoder that was too loose would then show stray bits or changed pad outputs.

// File: rtl/gpio2_pkg.sv
package gpio2_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int NPINS    = 2;
    localparam int DIR_LSB  = 4;
    localparam int SYNC_STG = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h40;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h41;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 8'h70;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_MODE
    } reg_sel_e;

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] dat;
    } pin_cfg_t;

    typedef struct packed {
        logic [NPINS-1:0] oe;
        logic [NPINS-1:0] val;
        logic [NPINS-1:0] ana;
    } pad_drive_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a == ADDR_CTRL)      s = SEL_CTRL;
        else if (a == ADDR_STAT) s = SEL_STAT;
        else if (a == ADDR_MODE) s = SEL_MODE;
        else                     s = SEL_NONE;
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input pin_cfg_t c);
        logic [DATA_W-1:0] b;
        b = '0;
        b[NPINS-1:0]          = c.dat;
        b[DIR_LSB +: NPINS]   = c.dir;
        return b;
    endfunction

    function automatic logic [DATA_W-1:0] pack_low(input logic [NPINS-1:0] v);
        logic [DATA_W-1:0] b;
        b = '0;
        b[NPINS-1:0] = v;
        return b;
    endfunction

endpackage

// File: rtl/gpio2_insync.sv
module gpio2_insync
    import gpio2_pkg::*;
#(
    parameter int WIDTH  = NPINS,
    parameter int STAGES = SYNC_STG
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= {chain_q[STAGES-2:0], raw_in[p]};
        end

        assign sync_out[p] = chain_q[LAST];
    end

endmodule

// File: rtl/gpio2_regbank.sv
module gpio2_regbank
    import gpio2_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  in_level,
    output pin_cfg_t          cfg,
    output logic [NPINS-1:0]  bypass
);

    reg_sel_e          sel;
    pin_cfg_t          cfg_q;
    logic [NPINS-1:0]  byp_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    assign sel = decode_addr(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.dir <= '1;
            cfg_q.dat <= '0;
        end else if (bus_wr && sel == SEL_CTRL) begin
            cfg_q.dat <= bus_wdata[NPINS-1:0];
            cfg_q.dir <= bus_wdata[DIR_LSB +: NPINS];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                             byp_q <= '0;
        else if (bus_wr && sel == SEL_MODE)  byp_q <= bus_wdata[NPINS-1:0];
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: rd_mux = pack_ctrl(cfg_q);
            SEL_STAT: rd_mux = pack_low(in_level & ~byp_q);
            SEL_MODE: rd_mux = pack_low(byp_q);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign cfg       = cfg_q;
    assign bypass    = byp_q;

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> $stable(bus_rdata));

    p_mode_write_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_wr) && $past(bus_addr) == ADDR_MODE && !$past(rst))
            |-> bypass == $past(bus_wdata[NPINS-1:0]));

endmodule

// File: rtl/gpio2_padctl.sv
module gpio2_padctl
    import gpio2_pkg::*;
(
    input  pin_cfg_t         cfg,
    input  logic [NPINS-1:0] bypass,
    output pad_drive_t       drv
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic digital_en;
        assign digital_en   = cfg.dir[p] & ~bypass[p];
        assign drv.oe[p]    = digital_en;
        assign drv.val[p]   = digital_en & cfg.dat[p];
        assign drv.ana[p]   = bypass[p];
    end

endmodule

// File: rtl/gpio2_port.sv
module gpio2_port
    import gpio2_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    input  logic [1:0]  pad_in,
    output logic [1:0]  pad_oe,
    output logic [1:0]  pad_out,
    output logic [1:0]  ana_sel
);

    pin_cfg_t         cfg;
    logic [NPINS-1:0] bypass;
    logic [NPINS-1:0] in_sync;
    pad_drive_t       drv;

    gpio2_insync #(.WIDTH(NPINS), .STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (pad_in),
        .sync_out (in_sync)
    );

    gpio2_regbank u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .in_level  (in_sync),
        .cfg       (cfg),
        .bypass    (bypass)
    );

    gpio2_padctl u_pads (
        .cfg    (cfg),
        .bypass (bypass),
        .drv    (drv)
    );

    assign pad_oe  = drv.oe;
    assign pad_out = drv.val;
    assign ana_sel = drv.ana;

    p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == 2'b11 && pad_out == 2'b00 && ana_sel == 2'b00));

    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_CTRL && ana_sel == 2'b00 &&
         !(bus_wr && bus_addr == ADDR_MODE))
            |=> pad_oe == $past(bus_wdata[DIR_LSB +: NPINS]));

    p_bypass_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ana_sel[0]) |-> ($past(bus_wr) && $past(bus_addr) == ADDR_MODE));

    p_bypass_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (ana_sel & pad_oe) == 2'b00);

    p_sync_delay_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> in_sync == $past(pad_in, 2));

endmodule

// File: tb/gpio2_port_bench.sv
module gpio2_port_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr  = '0;
    logic       bus_wr    = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd    = 1'b0;
    logic [7:0] bus_rdata;
    logic [1:0] pad_in;
    logic [1:0] pad_oe;
    logic [1:0] pad_out;
    logic [1:0] ana_sel;
    logic [1:0] ext_lvl = 2'b00;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    for (genvar i = 0; i < 2; i++) begin : g_pad
        assign pad_in[i] = pad_oe[i] ? pad_out[i] : ext_lvl[i];
    end

    gpio2_port u_gpio2_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .ana_sel(ana_sel)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 oe", {6'b0, pad_oe}, 8'h03);
        chk("R1 out", {6'b0, pad_out}, 8'h00);
        chk("R1 ana", {6'b0, ana_sel}, 8'h00);
        bus_read(8'h40, d); chk("R1 ctrl", d, 8'h30);
        bus_read(8'h70, d); chk("R1 mode", d, 8'h00);
    endtask

    task automatic t_ctrl_write();
        logic [7:0] d;
        bus_write(8'h40, 8'hFF);
        chk("R2 oe after write", {6'b0, pad_oe}, 8'h03);
        chk("R2 out after write", {6'b0, pad_out}, 8'h03);
        bus_read(8'h40, d); chk("R2 reserved bits", d, 8'h33);
        bus_write(8'h40, 8'h12);
        chk("R2 mixed oe", {6'b0, pad_oe}, 8'h01);
        bus_read(8'h40, d); chk("R2 mixed readback", d, 8'h12);
    endtask

    task automatic t_direction();
        bus_write(8'h40, 8'h23);
        chk("R3 pin1 drives", {6'b0, pad_oe}, 8'h02);
        chk("R3 hiz pin out low", {6'b0, pad_out}, 8'h02);
        bus_write(8'h40, 8'h03);
        chk("R3 all input", {6'b0, pad_oe}, 8'h00);
        chk("R3 all input out", {6'b0, pad_out}, 8'h00);
    endtask

    task automatic t_input_sync();
        logic [7:0] d;
        bus_write(8'h40, 8'h00);
        ext_lvl = 2'b00;
        idle(4);
        @(negedge clk);
        ext_lvl = 2'b10;
        bus_addr = 8'h41; bus_rd = 1'b1;
        @(negedge clk);
        chk("R4 edge1 old", bus_rdata, 8'h00);
        @(negedge clk);
        chk("R4 edge2 old", bus_rdata, 8'h00);
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R4 edge3 new", bus_rdata, 8'h02);
        ext_lvl = 2'b01;
        idle(3);
        bus_read(8'h41, d); chk("R4 pin0 high", d, 8'h01);
    endtask

    task automatic t_readback();
        logic [7:0] d;
        ext_lvl = 2'b00;
        bus_write(8'h40, 8'h31);
        idle(3);
        bus_read(8'h41, d); chk("R5 driven level reads back", d, 8'h01);
        bus_write(8'h40, 8'h32);
        idle(3);
        bus_read(8'h41, d); chk("R5 driven pin1", d, 8'h02);
    endtask

    task automatic t_ro_status();
        logic [7:0] d;
        bus_write(8'h40, 8'h31);
        bus_write(8'h41, 8'hFF);
        chk("R6 pads unchanged", {4'b0, pad_oe, pad_out}, 8'h0D);
        bus_read(8'h40, d); chk("R6 ctrl unchanged", d, 8'h31);
        bus_read(8'h70, d); chk("R6 mode unchanged", d, 8'h00);
    endtask

    task automatic t_bypass();
        logic [7:0] d;
        ext_lvl = 2'b11;
        bus_write(8'h40, 8'h33);
        bus_write(8'h70, 8'hFD);
        chk("R8 pin0 ana", {6'b0, ana_sel}, 8'h01);
        chk("R8 pin0 oe forced off", {6'b0, pad_oe}, 8'h02);
        chk("R8 pin0 out low", {6'b0, pad_out}, 8'h02);
        bus_read(8'h70, d); chk("R7 mode readback", d, 8'h01);
        idle(3);
        bus_read(8'h41, d); chk("R8 status masked", d, 8'h02);
        bus_write(8'h70, 8'h02);
        chk("R7 pin1 bypass", {4'b0, ana_sel, pad_oe}, 8'h09);
        bus_write(8'h70, 8'h00);
        chk("R8 restore", {2'b0, ana_sel, pad_oe, pad_out}, 8'h0F);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        bus_write(8'h42, 8'hFF);
        bus_write(8'h71, 8'hFF);
        bus_write(8'h00, 8'hFF);
        chk("R9 pads unchanged", {2'b0, ana_sel, pad_oe, pad_out}, 8'h0F);
        bus_read(8'h42, d); chk("R9 read 0x42", d, 8'h00);
        bus_read(8'hFF, d); chk("R9 read 0xFF", d, 8'h00);
        bus_read(8'h70, d); chk("R9 mode intact", d, 8'h00);
    endtask

    task automatic t_rdata_hold();
        logic [7:0] d;
        bus_read(8'h40, d); chk("R10 read", d, 8'h33);
        @(negedge clk); bus_addr = 8'h70;
        bus_write(8'h40, 8'h10);
        idle(2);
        chk("R10 held", bus_rdata, 8'h33);
    endtask

    initial begin
        idle(3);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_ctrl_write();
        t_direction();
        t_input_sync();
        t_readback();
        t_ro_status();
        t_bypass();
        t_unmapped();
        t_rdata_hold();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule